// File: doc/BRIEF.md
# I2C Slave Receive Engine with Status Codes

This block is the receive side of an I2C slave peripheral. Its bus inputs are SCL and SDA, already synchronised to the system clock. It detects START and STOP conditions and shifts in the address byte that follows a START. It accepts that byte if it matches a programmable 7-bit own address with the write direction. If general call is enabled, it also accepts the all-zero address. After accepting an address it acknowledges every data byte that follows. To acknowledge, it pulls SDA low through an open-drain style output.

Software sees the block through a small set of registers. Each significant bus event produces an 8-bit status code and raises an interrupt flag. The data register holds the last accepted byte. The address register holds the own address and a general-call enable. A one-cycle pulse clears the interrupt flag. While the flag is set after a byte event, the block holds SCL low, which stretches the bus until software has serviced the event. Misplaced START or STOP conditions are reported as a bus error, and the engine then drops back to the unaddressed state.

Top module: `i2cs_slave_rx`

## Requirements
- R1: After reset the interrupt flag is 0, the status reads F8h, the data register reads 00h, and neither SCL nor SDA is pulled low.
- R2: After a START, a received address byte whose upper 7 bits equal `addr_reg_i[7:1]` and whose last (direction) bit is 0 is acknowledged by pulling SDA low for the whole ninth clock. At the falling SCL edge that ends the ninth clock, the flag is set with status 60h.
- R3: `addr_reg_i[0]` gates general call. When it is 1, an address byte of 00h is acknowledged with status 70h. When it is 0, an address byte of 00h that does not match the own address is not acknowledged, and the flag is not set.
- R4: An address byte with direction bit 1, or one with a non-matching address, gets no acknowledge and sets no flag. The data bytes that follow are ignored until the next START.
- R5: Once the engine is addressed, each data byte is acknowledged. The byte is placed in the data register at the falling edge of its eighth clock, which comes before the flag is set. The status is 80h after an own-address match and 90h after a general-call match.
- R6: While the flag is set after an address or data byte, SCL is held low. SCL is released in the cycle the flag clears.
- R7: The three low status bits are always 0. A newly set flag always comes with a code other than F8h. After the flag clears, the old code stays for one more cycle and the status then reads F8h.
- R8: A STOP or repeated START seen during the first bit period of a byte while addressed sets the flag with status A0h and does not hold SCL. After a repeated START, a new address byte is received normally.
- R9: A START or STOP seen later than the first bit period of an address or data byte, or during an acknowledge bit, sets the flag with status 00h. In that case both lines are released, and all bus activity is ignored until the next START.
- R10: While `master_mode_i` is 1, the address register is ignored: no address is acknowledged and no flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL bus level |
| sda_i | input | 1 | Synchronised SDA bus level |
| master_mode_i | input | 1 | Port in master mode; slave matching disabled |
| addr_reg_i | input | 8 | Own address in bits 7..1, general-call enable in bit 0 |
| si_clr_i | input | 1 | One-cycle pulse clearing the interrupt flag |
| si_o | output | 1 | Interrupt flag |
| status_o | output | 8 | Status code, low three bits zero |
| data_o | output | 8 | Last accepted byte |
| scl_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_low_o | output | 1 | Pull SDA low (acknowledge) |

## Verification
The bench builds the block with the default address width of 7, so the address byte, data byte and acknowledge slot have their usual 8- and 9-clock shapes. It models the wired-AND bus, which means the acknowledge and the clock stretch are observed on the bus levels the engine itself reads. The own address 5Ah is used with the general-call bit both clear and set, so one build covers own-address, general-call, read-direction, mismatch, repeated-START, STOP, mid-byte error and master-mode cases.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int STAT_W   = 8;
  localparam int LSB_ZERO = 3;
  localparam int CODE_W   = STAT_W - LSB_ZERO;

  localparam logic [STAT_W-1:0] CODE_IDLE     = 8'hF8;
  localparam logic [STAT_W-1:0] CODE_BUS_ERR  = 8'h00;
  localparam logic [STAT_W-1:0] CODE_OWN_W    = 8'h60;
  localparam logic [STAT_W-1:0] CODE_GC_W     = 8'h70;
  localparam logic [STAT_W-1:0] CODE_OWN_DATA = 8'h80;
  localparam logic [STAT_W-1:0] CODE_GC_DATA  = 8'h90;
  localparam logic [STAT_W-1:0] CODE_STOP_RS  = 8'hA0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/i2cs_bus_cond.sv
module i2cs_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA edge while SCL stays high
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2cs_shifter.sv
module i2cs_shifter #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              full_o
);
  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (shift_i && !full_o) begin
      sh_q  <= {sh_q[BYTE_W-2:0], bit_i};
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign byte_o = sh_q;
  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CNT_W'(BYTE_W));
endmodule

// File: rtl/i2cs_irq.sv
module i2cs_irq
  import i2cs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic              stretch_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              si_o,
  output logic              stretch_o,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] IDLE_C = CODE_IDLE[STAT_W-1:LSB_ZERO];

  logic si_q, si_prev_q, stretch_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      si_q      <= 1'b0;
      si_prev_q <= 1'b0;
      stretch_q <= 1'b0;
      code_q    <= IDLE_C;
    end else begin
      si_prev_q <= si_q;
      if (set_i) begin
        si_q      <= 1'b1;
        stretch_q <= stretch_i;
        code_q    <= code_i;
      end else begin
        if (clr_i) begin
          si_q      <= 1'b0;
          stretch_q <= 1'b0;
        end
        // keep old code one cycle past the clear
        if (si_prev_q && !si_q) code_q <= IDLE_C;
      end
    end
  end

  assign si_o      = si_q;
  assign stretch_o = stretch_q;
  assign code_o    = code_q;
endmodule

// File: rtl/i2cs_slave_rx.sv
module i2cs_slave_rx
  import i2cs_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1,
  localparam int CNT_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              master_mode_i,
  input  logic [BYTE_W-1:0] addr_reg_i,
  input  logic              si_clr_i,
  output logic              si_o,
  output logic [STAT_W-1:0] status_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              scl_low_o,
  output logic              sda_low_o
);
  logic scl_rise, scl_fall, start_c, stop_c;
  logic sh_clr, sh_en, full;
  logic [BYTE_W-1:0] rx_byte;
  logic [CNT_W-1:0]  cnt;

  rx_state_e st_q, st_d;
  logic gc_q, gc_d, sda_q, sda_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic set, stretch;
  logic [STAT_W-1:0] code;
  logic [CODE_W-1:0] code_q;
  logic stretch_q;

  i2cs_bus_cond u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  i2cs_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i, .rst_ni, .clr_i(sh_clr), .shift_i(sh_en), .bit_i(sda_i),
    .byte_o(rx_byte), .cnt_o(cnt), .full_o(full)
  );

  i2cs_irq u_irq (
    .clk_i, .rst_ni, .set_i(set), .clr_i(si_clr_i), .stretch_i(stretch),
    .code_i(code[STAT_W-1:LSB_ZERO]),
    .si_o, .stretch_o(stretch_q), .code_o(code_q)
  );

  logic gc_hit, own_hit, framed, legal;
  assign gc_hit  = addr_reg_i[0] && (rx_byte == '0);
  assign own_hit = (rx_byte[BYTE_W-1:1] == addr_reg_i[BYTE_W-1:1]) && !rx_byte[0];
  assign framed  = st_q inside {ST_ADDR, ST_ADDR_ACK, ST_DATA, ST_DATA_ACK};
  // condition allowed only within first bit period of a byte
  assign legal   = (st_q inside {ST_ADDR, ST_DATA}) && (cnt <= CNT_W'(1));

  always_comb begin
    st_d    = st_q;
    gc_d    = gc_q;
    sda_d   = sda_q;
    data_d  = data_q;
    set     = 1'b0;
    stretch = 1'b0;
    code    = CODE_IDLE;
    sh_clr  = 1'b0;
    sh_en   = 1'b0;
    if (master_mode_i) begin
      st_d  = ST_IDLE;
      sda_d = 1'b0;
    end else if ((start_c || stop_c) && framed && !legal) begin
      set   = 1'b1;
      code  = CODE_BUS_ERR;
      st_d  = ST_IDLE;
      sda_d = 1'b0;
    end else if (start_c) begin
      if (st_q == ST_DATA) begin
        set  = 1'b1;
        code = CODE_STOP_RS;
      end
      st_d   = ST_ADDR;
      sh_clr = 1'b1;
    end else if (stop_c) begin
      if (st_q == ST_DATA) begin
        set  = 1'b1;
        code = CODE_STOP_RS;
      end
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_ADDR: begin
          if (scl_rise) sh_en = 1'b1;
          else if (scl_fall && full) begin
            if (gc_hit || own_hit) begin
              st_d   = ST_ADDR_ACK;
              sda_d  = 1'b1;
              data_d = rx_byte;
              gc_d   = gc_hit;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        ST_DATA: begin
          if (scl_rise) sh_en = 1'b1;
          else if (scl_fall && full) begin
            st_d   = ST_DATA_ACK;
            sda_d  = 1'b1;
            data_d = rx_byte;
          end
        end
        ST_ADDR_ACK, ST_DATA_ACK: begin
          if (scl_fall) begin
            sda_d   = 1'b0;
            set     = 1'b1;
            stretch = 1'b1;
            sh_clr  = 1'b1;
            st_d    = ST_DATA;
            if (st_q == ST_ADDR_ACK) code = gc_q ? CODE_GC_W : CODE_OWN_W;
            else                     code = gc_q ? CODE_GC_DATA : CODE_OWN_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      gc_q   <= 1'b0;
      sda_q  <= 1'b0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      gc_q   <= gc_d;
      sda_q  <= sda_d;
      data_q <= data_d;
    end
  end

  assign status_o  = {code_q, {LSB_ZERO{1'b0}}};
  assign data_o    = data_q;
  assign sda_low_o = sda_q;
  assign scl_low_o = si_o & stretch_q;
endmodule

// File: rtl/i2cs_slave_rx_chk.sv
module i2cs_slave_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       master_mode_i,
  input logic       si_o,
  input logic [7:0] status_o,
  input logic       scl_low_o,
  input logic       sda_low_o
);
  assert_idle_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!si_o && !$past(si_o)) |-> status_o == 8'hF8);

  assert_code_on_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(si_o) |-> status_o != 8'hF8);

  assert_hold_after_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(si_o) |-> $stable(status_o));

  assert_stretch_needs_si_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_low_o |-> si_o);

  assert_err_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (si_o && status_o == 8'h00) |-> (!sda_low_o && !scl_low_o));

  assert_master_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_mode_i |=> !sda_low_o);

  assert_ack_end_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sda_low_o) && !$past(master_mode_i)) |-> si_o);
endmodule

bind i2cs_slave_rx i2cs_slave_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .master_mode_i(master_mode_i),
  .si_o(si_o), .status_o(status_o), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o)
);

// File: tb/i2cs_slave_rx_bench.sv
module i2cs_slave_rx_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic m_scl = 1'b1, m_sda = 1'b1, master_mode = 1'b0, si_clr = 1'b0;
  logic [7:0] addr_reg = 8'hB4;
  logic si_o, scl_low_o, sda_low_o;
  logic [7:0] status_o, data_o;
  logic scl_bus, sda_bus;
  assign scl_bus = m_scl & ~scl_low_o;
  assign sda_bus = m_sda & ~sda_low_o;

  i2cs_slave_rx u_i2cs_slave_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_bus), .sda_i(sda_bus),
    .master_mode_i(master_mode), .addr_reg_i(addr_reg), .si_clr_i(si_clr),
    .si_o(si_o), .status_o(status_o), .data_o(data_o),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o)
  );

  int nchk = 0, nbad = 0;
  bit run_cmp = 0, done = 0;
  string cur_req = "R1";
  logic exp_si = 0, exp_scl = 0, exp_sda = 0;
  logic [7:0] exp_status = 8'hF8, exp_data = 8'h00;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle reference comparison, sampled 1 ns after the edge
  always @(posedge clk_i) begin
    #1;
    if (run_cmp && !done) begin
      check(si_o === exp_si, cur_req, "si", si_o, exp_si);
      check(status_o === exp_status, cur_req, "status", status_o, exp_status);
      check(data_o === exp_data, cur_req, "data", data_o, exp_data);
      check(sda_low_o === exp_sda, cur_req, "sda_low", sda_low_o, exp_sda);
      check(scl_low_o === exp_scl, cur_req, "scl_low", scl_low_o, exp_scl);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic post(input logic [7:0] code, input logic hold);
    exp_si = 1'b1; exp_status = code; exp_scl = hold;
  endtask

  task automatic clear_si();
    si_clr = 1'b1; exp_si = 1'b0; exp_scl = 1'b0;
    tick(1);
    si_clr = 1'b0; exp_status = 8'hF8;
    tick(1);
  endtask

  task automatic do_start(input bit ev);
    m_sda = 1'b1; tick(2);
    m_scl = 1'b1; tick(3);
    m_sda = 1'b0;
    if (ev) post(8'hA0, 1'b0);
    tick(3);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic do_stop(input bit ev);
    m_sda = 1'b0; tick(2);
    m_scl = 1'b1; tick(3);
    m_sda = 1'b1;
    if (ev) post(8'hA0, 1'b0);
    tick(3);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit ack, input logic [7:0] code);
    for (int i = 7; i >= 0; i--) begin
      m_sda = v[i]; tick(2);
      m_scl = 1'b1; tick(3);
      m_scl = 1'b0;
      if (i == 0 && ack) begin exp_sda = 1'b1; exp_data = v; end
      tick(2);
    end
    m_sda = 1'b1; tick(2);
    m_scl = 1'b1; tick(2);
    check(sda_bus == !ack, cur_req, "ack level on bus", sda_bus, !ack);
    tick(1);
    m_scl = 1'b0;
    if (ack) begin exp_sda = 1'b0; post(code, 1'b1); end
    tick(2);
  endtask

  // k bits then START (cond=1) or STOP (cond=0) in mid-byte
  task automatic cut_byte(input int k, input bit cond);
    for (int i = 0; i < k; i++) begin
      m_sda = i[0]; tick(2);
      m_scl = 1'b1; tick(3);
      m_scl = 1'b0; tick(2);
    end
    m_sda = cond; tick(2);
    m_scl = 1'b1; tick(3);
    m_sda = !cond;
    exp_sda = 1'b0; post(8'h00, 1'b0);
    tick(3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    nchk++; nbad++;
    $display("FAIL R1 watchdog: actual %0d expected %0d", 150000, 0);
    finish_run();
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    cur_req = "R1";
    check(si_o == 0, "R1", "reset si", si_o, 0);
    check(status_o == 8'hF8, "R1", "reset status", status_o, 8'hF8);
    check(data_o == 0, "R1", "reset data", data_o, 0);
    check(!scl_low_o && !sda_low_o, "R1", "reset drive", {scl_low_o, sda_low_o}, 0);
    run_cmp = 1;

    // own address write, two data bytes, STOP
    cur_req = "R2";
    do_start(0);
    send_byte(8'hB4, 1, 8'h60);
    check(status_o == 8'h60, "R2", "own addr status", status_o, 8'h60);
    check(data_o == 8'hB4, "R5", "addr byte in data", data_o, 8'hB4);
    check(scl_low_o == 1, "R6", "scl held", scl_low_o, 1);
    tick(4);
    check(scl_bus == 0, "R6", "bus scl while flagged", scl_bus, 0);
    cur_req = "R7";
    clear_si();
    check(scl_low_o == 0, "R6", "scl released", scl_low_o, 0);
    check(status_o == 8'hF8, "R7", "idle after clear", status_o, 8'hF8);
    cur_req = "R5";
    send_byte(8'h3C, 1, 8'h80);
    check(data_o == 8'h3C && status_o == 8'h80, "R5", "data byte 1", data_o, 8'h3C);
    check(status_o[2:0] == 0, "R7", "low status bits", status_o[2:0], 0);
    clear_si();
    send_byte(8'hC3, 1, 8'h80);
    check(data_o == 8'hC3, "R5", "data byte 2", data_o, 8'hC3);
    clear_si();
    cur_req = "R8";
    do_stop(1);
    check(status_o == 8'hA0 && scl_low_o == 0, "R8", "stop code", status_o, 8'hA0);
    clear_si();

    // read direction and mismatch ignored
    cur_req = "R4";
    do_start(0);
    send_byte(8'hB5, 0, 8'h00);
    send_byte(8'h11, 0, 8'h00);
    check(si_o == 0 && data_o == 8'hC3, "R4", "read addr ignored", si_o, 0);
    do_stop(0);
    do_start(0);
    send_byte(8'h20, 0, 8'h00);
    send_byte(8'hB4, 0, 8'h00);
    check(si_o == 0, "R4", "mismatch ignored", si_o, 0);
    do_stop(0);

    // general call disabled, then enabled
    cur_req = "R3";
    do_start(0);
    send_byte(8'h00, 0, 8'h00);
    check(si_o == 0 && status_o == 8'hF8, "R3", "gc disabled", si_o, 0);
    do_stop(0);
    addr_reg = 8'hB5;
    tick(2);
    do_start(0);
    send_byte(8'h00, 1, 8'h70);
    check(status_o == 8'h70, "R3", "gc enabled", status_o, 8'h70);
    clear_si();
    cur_req = "R5";
    send_byte(8'h77, 1, 8'h90);
    check(status_o == 8'h90 && data_o == 8'h77, "R5", "gc data", status_o, 8'h90);
    clear_si();
    cur_req = "R8";
    do_start(1);
    check(status_o == 8'hA0, "R8", "repeated start code", status_o, 8'hA0);
    clear_si();
    send_byte(8'hB4, 1, 8'h60);
    check(status_o == 8'h60, "R8", "addr after restart", status_o, 8'h60);
    clear_si();
    do_stop(1);
    clear_si();

    // bus errors
    cur_req = "R9";
    do_start(0);
    send_byte(8'hB4, 1, 8'h60);
    clear_si();
    cut_byte(3, 0);
    check(status_o == 8'h00 && sda_low_o == 0, "R9", "stop in data byte", status_o, 8'h00);
    clear_si();
    send_byte(8'hB4, 0, 8'h00);
    check(si_o == 0, "R9", "ignored until start", si_o, 0);
    do_stop(0);
    do_start(0);
    cut_byte(4, 1);
    check(status_o == 8'h00 && scl_low_o == 0, "R9", "start in addr byte", status_o, 8'h00);
    clear_si();
    m_scl = 1'b0; tick(2);
    do_stop(0);

    // master mode
    cur_req = "R10";
    master_mode = 1'b1;
    do_start(0);
    send_byte(8'hB4, 0, 8'h00);
    check(si_o == 0 && sda_low_o == 0, "R10", "no slave response", si_o, 0);
    do_stop(0);
    master_mode = 1'b0;

    // recovery
    cur_req = "R2";
    do_start(0);
    send_byte(8'hB4, 1, 8'h60);
    check(status_o == 8'h60, "R2", "recovered", status_o, 8'h60);
    clear_si();
    do_stop(1);
    clear_si();
    tick(4);
    finish_run();
  end
endmodule